// File: doc/BRIEF.md
# Voice Interrupt Pending Scanner

This block keeps the interrupt requests raised by a bank of up to 31 synthesis voices. Each voice can raise two kinds of request: an end-of-wavetable request and a volume-ramp request. Each kind has its own pending vector. A per-voice set strobe marks a voice pending. Every request also sets a summary bit that feeds the shared interrupt status of the sound engine.

The host acknowledges one request at a time. It does this by writing the acknowledge code 0x8F into the function-select register. On that write the block looks for a pending voice and serves the one it finds. It clears the voice's pending bit and sends a one-cycle clear strobe to that voice's control flag. It then latches a result byte that the host reads back: the voice number in the low five bits and a type tag in the upper three bits. A board-level clear empties both vectors at once.

Top module: `voice_irq_scanner`

## Requirements
- R1: A scan happens only in a cycle where `sel_wr` is high and `sel_data` equals 0x8F. In any other cycle `result` keeps its value and both clear-strobe outputs stay zero.
- R2: If any wavetable voice is pending when the acknowledge arrives, a wavetable voice is served. A ramp voice is served only when no wavetable voice is pending.
- R3: Within a vector, the lowest pending voice index in the range 0 to NUM_VOICES-1 is served. Exactly one voice is served per acknowledge.
- R4: Serving wavetable voice v does three things. It clears pending bit v. It pulses `wt_flag_clr[v]` high for the one cycle after the acknowledge edge. It latches `result` = {3'b011, v[4:0]}, that is v | 0x60.
- R5: Serving ramp voice v does three things. It clears ramp pending bit v. It pulses `ramp_flag_clr[v]` for one cycle. It latches `result` = {3'b100, v[4:0]}, that is v | 0x80.
- R6: An acknowledge with nothing pending latches `result` = 0xE8. After `rst_n`, `result` is 0xE8 and both vectors are empty.
- R7: `wt_summary` (interrupt-status bit 5) and `ramp_summary` (bit 6) go high on the edge after a set strobe of their kind. Each goes low on the edge where a scan or a board clear leaves its vector empty.
- R8: `irq_line` is high exactly when `wt_summary`, `ramp_summary` or `other_irq` is high.
- R9: A `board_clr` pulse empties both vectors and both summary bits. It wins over set strobes in the same cycle and leaves `result` unchanged.
- R10: A set strobe for a voice in the same cycle as that voice is served leaves the voice pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wt_set | input | NUM_VOICES | Per-voice wavetable-end request strobes |
| ramp_set | input | NUM_VOICES | Per-voice volume-ramp request strobes |
| sel_wr | input | 1 | Write strobe of the function-select register |
| sel_data | input | 8 | Value written to the function-select register |
| board_clr | input | 1 | Board reset pulse; empties both pending vectors |
| other_irq | input | 1 | OR of the other interrupt-status sources |
| result | output | 8 | Latched acknowledge result byte |
| wt_flag_clr | output | NUM_VOICES | One-cycle clear strobe for a voice's control IRQ flag |
| ramp_flag_clr | output | NUM_VOICES | One-cycle clear strobe for a voice's ramp-control IRQ flag |
| wt_summary | output | 1 | Interrupt-status bit 5: wavetable requests pending |
| ramp_summary | output | 1 | Interrupt-status bit 6: ramp requests pending |
| irq_line | output | 1 | Interrupt line to the host |

## Verification
The bench fills both vectors with voices on both sides, including voice 30 at the top of the range. It then acknowledges repeatedly.
- A design that searched from the wrong end, or served ramp before wavetable, would latch the wrong result byte in that run.
- A design that served two voices per acknowledge would latch the wrong byte on the following acknowledge.
- Writes of a code other than 0x8F must change nothing. A decoder that ignored the data would serve a voice on that write.
- A set strobe that coincides with its own clear must leave the voice pending. A design that ordered the clear last would return 0xE8 on the next acknowledge.
- A board clear in the same cycle as a set strobe must win. The bench checks that the summary bits drop and that `irq_line` then follows `other_irq` alone.

// File: rtl/vis_pkg.sv
package vis_pkg;
    localparam int VOICE_W = 5;
    localparam logic [7:0] ACK_CODE = 8'h8F;
    localparam logic [7:0] RES_NONE = 8'hE8;
    localparam logic [2:0] TAG_WT   = 3'b011;
    localparam logic [2:0] TAG_RAMP = 3'b100;

    function automatic logic [7:0] make_result(input logic [2:0] tag,
                                               input logic [VOICE_W-1:0] v);
        return {tag, v};
    endfunction
endpackage

// File: rtl/vis_first_set.sv
module vis_first_set #(
    parameter int W = 31,
    parameter int IDX_W = 5
) (
    input  logic [W-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/vis_onehot_dec.sv
module vis_onehot_dec #(
    parameter int W = 31,
    parameter int IDX_W = 5
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     mask
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        assign mask[g] = en && (idx == IDX_W'(g));
    end
endmodule

// File: rtl/voice_irq_scanner.sv
module voice_irq_scanner
    import vis_pkg::*;
#(
    parameter int NUM_VOICES = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_VOICES-1:0] wt_set,
    input  logic [NUM_VOICES-1:0] ramp_set,
    input  logic                  sel_wr,
    input  logic [7:0]            sel_data,
    input  logic                  board_clr,
    input  logic                  other_irq,
    output logic [7:0]            result,
    output logic [NUM_VOICES-1:0] wt_flag_clr,
    output logic [NUM_VOICES-1:0] ramp_flag_clr,
    output logic                  wt_summary,
    output logic                  ramp_summary,
    output logic                  irq_line
);
    localparam int NV = NUM_VOICES;

    typedef struct packed {
        logic [NV-1:0] wt_vec;
        logic [NV-1:0] rp_vec;
        logic          wt_sum;
        logic          rp_sum;
        logic [7:0]    res;
        logic [NV-1:0] wt_clr;
        logic [NV-1:0] rp_clr;
    } state_t;

    state_t st_q, st_d;

    logic                ack;
    logic                wt_found, rp_found;
    logic [VOICE_W-1:0]  wt_idx, rp_idx;
    logic [NV-1:0]       wt_mask, rp_mask;
    logic                serve_wt, serve_rp;

    assign ack      = sel_wr && (sel_data == ACK_CODE);
    assign serve_wt = ack && wt_found;
    assign serve_rp = ack && !wt_found && rp_found;

    vis_first_set #(.W(NV), .IDX_W(VOICE_W)) u_wt_pick (
        .req(st_q.wt_vec), .found(wt_found), .idx(wt_idx));
    vis_first_set #(.W(NV), .IDX_W(VOICE_W)) u_rp_pick (
        .req(st_q.rp_vec), .found(rp_found), .idx(rp_idx));

    vis_onehot_dec #(.W(NV), .IDX_W(VOICE_W)) u_wt_dec (
        .en(serve_wt), .idx(wt_idx), .mask(wt_mask));
    vis_onehot_dec #(.W(NV), .IDX_W(VOICE_W)) u_rp_dec (
        .en(serve_rp), .idx(rp_idx), .mask(rp_mask));

    always_comb begin
        st_d        = st_q;
        st_d.wt_clr = wt_mask;
        st_d.rp_clr = rp_mask;
        if (ack) begin
            if (serve_wt)      st_d.res = make_result(TAG_WT, wt_idx);
            else if (serve_rp) st_d.res = make_result(TAG_RAMP, rp_idx);
            else               st_d.res = RES_NONE;
        end
        // a fresh set strobe is applied after the clear, so it wins
        st_d.wt_vec = (st_q.wt_vec & ~wt_mask) | wt_set;
        st_d.rp_vec = (st_q.rp_vec & ~rp_mask) | ramp_set;
        if (|wt_set)
            st_d.wt_sum = 1'b1;
        else if (serve_wt && ((st_q.wt_vec & ~wt_mask) == '0))
            st_d.wt_sum = 1'b0;
        if (|ramp_set)
            st_d.rp_sum = 1'b1;
        else if (serve_rp && ((st_q.rp_vec & ~rp_mask) == '0))
            st_d.rp_sum = 1'b0;
        if (board_clr) begin
            st_d.wt_vec = '0;
            st_d.rp_vec = '0;
            st_d.wt_sum = 1'b0;
            st_d.rp_sum = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.res <= RES_NONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign result        = st_q.res;
    assign wt_flag_clr   = st_q.wt_clr;
    assign ramp_flag_clr = st_q.rp_clr;
    assign wt_summary    = st_q.wt_sum;
    assign ramp_summary  = st_q.rp_sum;
    assign irq_line      = st_q.wt_sum | st_q.rp_sum | other_irq;

    a_r1_no_scan_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_wr && sel_data == ACK_CODE) |=> ($stable(result) && wt_flag_clr == '0
                                               && ramp_flag_clr == '0));

    a_r2_wt_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && st_q.wt_vec != '0) |=> (result[7:5] == TAG_WT && ramp_flag_clr == '0));

    a_r3_one_served: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({wt_flag_clr, ramp_flag_clr}) <= 1);

    a_r7_summary_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (wt_summary == (st_q.wt_vec != '0)) && (ramp_summary == (st_q.rp_vec != '0)));

    a_r9_board_clear: assert property (@(posedge clk) disable iff (!rst_n)
        board_clr |=> (!wt_summary && !ramp_summary));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (!board_clr && wt_set != '0) |=> ((st_q.wt_vec & $past(wt_set)) == $past(wt_set)));
endmodule

// File: tb/voice_irq_scanner_test.sv
module voice_irq_scanner_test;
    localparam int NV = 31;
    localparam logic [5:0] NO = 6'd63;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NV-1:0] wt_set = '0, ramp_set = '0;
    logic sel_wr = 1'b0;
    logic [7:0] sel_data = '0;
    logic board_clr = 1'b0, other_irq = 1'b0;
    logic [7:0] result;
    logic [NV-1:0] wt_flag_clr, ramp_flag_clr;
    logic wt_summary, ramp_summary, irq_line;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    voice_irq_scanner #(.NUM_VOICES(NV)) uut (
        .clk(clk), .rst_n(rst_n), .wt_set(wt_set), .ramp_set(ramp_set),
        .sel_wr(sel_wr), .sel_data(sel_data), .board_clr(board_clr),
        .other_irq(other_irq), .result(result), .wt_flag_clr(wt_flag_clr),
        .ramp_flag_clr(ramp_flag_clr), .wt_summary(wt_summary),
        .ramp_summary(ramp_summary), .irq_line(irq_line));

    // row: wt voice, ramp voice, ack, result, wt_sum, rp_sum, wt clr voice, rp clr voice
    localparam int ROWS = 10;
    localparam logic [34:0] TABLE [ROWS] = '{
        {6'd3,  6'd0,  1'b0, 8'hE8, 1'b1, 1'b1, NO,    NO  },
        {6'd7,  NO,    1'b0, 8'hE8, 1'b1, 1'b1, NO,    NO  },
        {NO,    NO,    1'b1, 8'h63, 1'b1, 1'b1, 6'd3,  NO  },
        {NO,    NO,    1'b1, 8'h67, 1'b0, 1'b1, 6'd7,  NO  },
        {NO,    NO,    1'b1, 8'h80, 1'b0, 1'b0, NO,    6'd0},
        {NO,    NO,    1'b1, 8'hE8, 1'b0, 1'b0, NO,    NO  },
        {6'd30, 6'd30, 1'b0, 8'hE8, 1'b1, 1'b1, NO,    NO  },
        {NO,    NO,    1'b1, 8'h7E, 1'b0, 1'b1, 6'd30, NO  },
        {6'd1,  NO,    1'b0, 8'h7E, 1'b1, 1'b1, NO,    NO  },
        {NO,    NO,    1'b1, 8'h61, 1'b0, 1'b1, 6'd1,  NO  }
    };

    function automatic logic [NV-1:0] vmask(input logic [5:0] v);
        return (v < 6'(NV)) ? (NV'(1) << v) : '0;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [NV-1:0] ws, input logic [NV-1:0] rs,
                        input logic wr, input logic [7:0] d, input logic bc);
        wt_set = ws; ramp_set = rs; sel_wr = wr; sel_data = d; board_clr = bc;
        @(negedge clk);
        wt_set = '0; ramp_set = '0; sel_wr = 1'b0; sel_data = '0; board_clr = 1'b0;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        chk("R6 reset result", 32'(result), 32'hE8);
        chk("R7 reset summaries", {30'd0, wt_summary, ramp_summary}, 32'd0);
        chk("R8 reset irq_line", 32'(irq_line), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < ROWS; i++) begin
            logic [34:0] r;
            r = TABLE[i];
            step(vmask(r[34:29]), vmask(r[28:23]), r[22], 8'h8F, 1'b0);
            chk("R2/R3/R4/R5/R6 result", 32'(result), 32'(r[21:14]));
            chk("R7 wt_summary", 32'(wt_summary), 32'(r[13]));
            chk("R7 ramp_summary", 32'(ramp_summary), 32'(r[12]));
            chk("R4 wt_flag_clr", 32'(wt_flag_clr), 32'(vmask(r[11:6])));
            chk("R5 ramp_flag_clr", 32'(ramp_flag_clr), 32'(vmask(r[5:0])));
            chk("R8 irq_line", 32'(irq_line), 32'(r[13] | r[12]));
        end

        // the ramp voice 30 is still pending; other select codes must not scan it
        step('0, '0, 1'b1, 8'h8E, 1'b0);
        chk("R1 other code result held", 32'(result), 32'h61);
        chk("R1 other code no clear", 32'(ramp_flag_clr), 32'd0);
        chk("R1 other code pending kept", 32'(ramp_summary), 32'd1);
        step('0, '0, 1'b0, 8'h8F, 1'b0);
        chk("R1 no write no scan", 32'(result), 32'h61);
        step('0, '0, 1'b1, 8'h8F, 1'b0);
        chk("R5 ramp voice 30", 32'(result), 32'h9E);
        chk("R5 ramp clr 30", 32'(ramp_flag_clr), 32'(vmask(6'd30)));
        chk("R7 ramp summary low", 32'(ramp_summary), 32'd0);

        // set in the same cycle as its own service
        step(vmask(6'd2), '0, 1'b0, 8'h00, 1'b0);
        step(vmask(6'd2), '0, 1'b1, 8'h8F, 1'b0);
        chk("R10 served result", 32'(result), 32'h62);
        chk("R10 still pending", 32'(wt_summary), 32'd1);
        step('0, '0, 1'b1, 8'h8F, 1'b0);
        chk("R10 served again", 32'(result), 32'h62);
        chk("R7 wt summary low", 32'(wt_summary), 32'd0);

        // board clear beats a simultaneous set
        step(vmask(6'd4), vmask(6'd9), 1'b0, 8'h00, 1'b0);
        other_irq = 1'b1;
        step(vmask(6'd5), '0, 1'b0, 8'h00, 1'b1);
        chk("R9 summaries cleared", {30'd0, wt_summary, ramp_summary}, 32'd0);
        chk("R9 result untouched", 32'(result), 32'h62);
        chk("R8 irq from other source", 32'(irq_line), 32'd1);
        other_irq = 1'b0;
        #1;
        chk("R8 irq drops", 32'(irq_line), 32'd0);
        step('0, '0, 1'b1, 8'h8F, 1'b0);
        chk("R9 vectors empty", 32'(result), 32'hE8);
        chk("R6 no clear when empty", 32'({wt_flag_clr, ramp_flag_clr}), 32'd0);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule